// File: doc/BRIEF.md
# Wide-Bus Address Phase Sequencer

This block sits on the initiator side of a PCI-style parallel bus that is 64 bits wide. It is split into a lower and an upper half, each with its own 32-bit address/data lines and 4-bit command/byte-enable lines. A request carries a 64-bit address, a bus command, write data with byte enables, a flag saying the transfer is 64 bits wide, and a flag saying whether the addressed target accepts 64-bit data phases. The sequencer turns the request into a cycle-by-cycle pattern on the bus lines. It issues one address cycle when the address fits in 32 bits and two when it does not. It then issues one or two data phases.

When two address cycles are needed, the first cycle carries the low address word with the dual-address command code. The second carries the high word with the real command. In both cycles the upper half of the bus mirrors the high address word and the real command. A 64-bit target can therefore decode the full address in the first cycle. When wide data goes to a narrow target, the upper data word and its byte enables move down to the lower half in a second data phase.

A new request is taken only while the block is idle. Consecutive transactions are therefore always separated by at least one idle cycle. This gives a slow-decoding bridge room for the extra address cycle.

Top module: `addr_phase_seq`

## Requirements
- R1: After reset, all bus outputs are zero, `bus_frame`, `addr_done` and `data_valid` are low, and `req_ready` is high.
- R2: If `req_addr[63:32]` is zero, exactly one address cycle follows in the cycle after acceptance. It carries `req_addr[31:0]` on `bus_ad_lo` and `req_cmd` on `bus_cbe_lo`, and both upper-half outputs are zero.
- R3: If `req_addr[63:32]` is nonzero, the first address cycle carries `req_addr[31:0]` on `bus_ad_lo` and the dual-address code (parameter `DAC_CODE`, default 4'b1101) on `bus_cbe_lo`.
- R4: The second address cycle of a dual address cycle carries `req_addr[63:32]` on `bus_ad_lo` and `req_cmd` on `bus_cbe_lo`.
- R5: In both cycles of a dual address cycle, `bus_ad_hi` equals `req_addr[63:32]` and `bus_cbe_hi` equals `req_cmd`.
- R6: `bus_frame` is high in every address cycle and in no other cycle. `addr_done` is high for exactly one cycle per transaction, namely the last address cycle.
- R7: With `req_wide` and `req_tgt_wide` both set, one data phase follows the address phase. It carries `req_data[31:0]`/`req_be[3:0]` on the lower half and `req_data[63:32]`/`req_be[7:4]` on the upper half.
- R8: With `req_wide` set and `req_tgt_wide` clear, two data phases follow on the lower half only. The first carries `req_data[31:0]`/`req_be[3:0]` and the second carries `req_data[63:32]`/`req_be[7:4]`. The upper half is zero in both.
- R9: With `req_wide` clear, one data phase carries `req_data[31:0]`/`req_be[3:0]` on the lower half, and the upper half is zero.
- R10: `req_ready` is high only in idle cycles, and `req_valid` while `req_ready` is low has no effect. At least one idle cycle separates the last data phase from the next address cycle.
- R11: `data_valid` is high exactly in data phases. In idle cycles all bus outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; request taken on this edge if valid |
| req_addr | input | 64 | Transaction address |
| req_cmd | input | 4 | Bus command |
| req_wide | input | 1 | Transfer uses 64-bit data |
| req_tgt_wide | input | 1 | Target accepts 64-bit data phases |
| req_data | input | 64 | Data for the data phase |
| req_be | input | 8 | Byte enables, bit 0 for the lowest byte |
| bus_ad_lo | output | 32 | Lower-half address/data lines |
| bus_ad_hi | output | 32 | Upper-half address/data lines |
| bus_cbe_lo | output | 4 | Lower-half command/byte-enable lines |
| bus_cbe_hi | output | 4 | Upper-half command/byte-enable lines |
| bus_frame | output | 1 | High during address cycles |
| addr_done | output | 1 | High in the last address cycle |
| data_valid | output | 1 | High during data phases |

## Verification
The hardest case to reach is the longest sequence: a dual address cycle followed by a split data phase. In this case the lower half carries four different words in four cycles, while the upper half must hold a mirrored value for two cycles and then fall to zero. Random requests pick the upper address word and the width flags independently, and directed requests pin the boundaries: an upper word of exactly 1, all ones, and zero. As a result, every pairing of one or two address cycles with one or two data phases occurs many times. Garbage requests are presented while the block is busy, which shows that nothing is taken until the idle cycle.

// File: rtl/aps_pkg.sv
// Shared widths, state encoding and captured-request layout for the
// address phase sequencer. Assumes the bus is two equal halves.
package aps_pkg;
    parameter int HALF_W = 32;
    parameter int CMD_W  = 4;
    localparam int FULL_W = 2 * HALF_W;
    localparam int BE_W   = HALF_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR1 = 3'd1,
        ST_ADDR2 = 3'd2,
        ST_DATA1 = 3'd3,
        ST_DATA2 = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic [HALF_W-1:0] addr_hi;
        logic [HALF_W-1:0] addr_lo;
        logic [CMD_W-1:0]  cmd;
        logic              wide;
        logic              tgt_wide;
        logic [HALF_W-1:0] data_hi;
        logic [HALF_W-1:0] data_lo;
        logic [BE_W-1:0]   be_hi;
        logic [BE_W-1:0]   be_lo;
    } req_t;
endpackage

// File: rtl/aps_req_hold.sv
// Holds the accepted request for the whole transaction.
// Assumes load is asserted only on the accepting edge.
module aps_req_hold
    import aps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  req_t d,
    output req_t q
);
    // Capture the request on acceptance, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q)); // R10
endmodule

// File: rtl/aps_fsm.sv
// Sequences idle, one or two address cycles and one or two data phases.
// Assumes dac and split come from the held request, valid from ST_ADDR1 on.
module aps_fsm
    import aps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       dac,
    input  logic       split,
    output seq_state_t state,
    output logic       ready,
    output logic       frame,
    output logic       last_addr,
    output logic       dphase
);
    seq_state_t nxt;

    // Choose the next step of the transaction.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  if (go) nxt = ST_ADDR1;
            ST_ADDR1: nxt = dac ? ST_ADDR2 : ST_DATA1;
            ST_ADDR2: nxt = ST_DATA1;
            ST_DATA1: nxt = split ? ST_DATA2 : ST_IDLE;
            ST_DATA2: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Advance the state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Decode phase flags from the state.
    always_comb begin
        ready     = (state == ST_IDLE);
        frame     = (state == ST_ADDR1) || (state == ST_ADDR2);
        last_addr = (state == ST_ADDR2) || ((state == ST_ADDR1) && !dac);
        dphase    = (state == ST_DATA1) || (state == ST_DATA2);
    end

    AST_DONE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        last_addr |-> frame); // R6
    AST_DONE_ENDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        last_addr |=> dphase && !frame); // R6
    AST_FIRST_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame && !last_addr) |=> (frame && last_addr)); // R4
    AST_GAP_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dphase) |-> (ready && !frame)); // R10
endmodule

// File: rtl/aps_bus_mux.sv
// Steers held address, command, data and byte enables onto the two bus halves
// according to the current phase. Pure combinational.
module aps_bus_mux
    import aps_pkg::*;
#(
    parameter logic [CMD_W-1:0] DAC_CODE = 4'b1101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state,
    input  req_t              rq,
    input  logic              dac,
    output logic [HALF_W-1:0] ad_lo,
    output logic [HALF_W-1:0] ad_hi,
    output logic [CMD_W-1:0]  cbe_lo,
    output logic [CMD_W-1:0]  cbe_hi
);
    // Drive both halves for each phase; idle drives zero.
    always_comb begin
        ad_lo  = '0;
        ad_hi  = '0;
        cbe_lo = '0;
        cbe_hi = '0;
        case (state)
            ST_ADDR1: begin
                ad_lo  = rq.addr_lo;
                cbe_lo = dac ? DAC_CODE : rq.cmd;
                if (dac) begin
                    ad_hi  = rq.addr_hi;
                    cbe_hi = rq.cmd;
                end
            end
            ST_ADDR2: begin
                ad_lo  = rq.addr_hi;
                cbe_lo = rq.cmd;
                ad_hi  = rq.addr_hi;
                cbe_hi = rq.cmd;
            end
            ST_DATA1: begin
                ad_lo  = rq.data_lo;
                cbe_lo = rq.be_lo;
                if (rq.wide && rq.tgt_wide) begin
                    ad_hi  = rq.data_hi;
                    cbe_hi = rq.be_hi;
                end
            end
            ST_DATA2: begin
                ad_lo  = rq.data_hi;
                cbe_lo = rq.be_hi;
            end
            default: ;
        endcase
    end

    AST_MIRROR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR1 && dac) |=> ($stable(ad_hi) && $stable(cbe_hi))); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (ad_lo == '0 && ad_hi == '0 && cbe_lo == '0 && cbe_hi == '0)); // R11
endmodule

// File: rtl/addr_phase_seq.sv
// Initiator-side address phase sequencer for a two-half bus: single or dual
// address cycle, then one or two data phases. Assumes one request at a time.
module addr_phase_seq
    import aps_pkg::*;
#(
    parameter logic [CMD_W-1:0] DAC_CODE = 4'b1101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [FULL_W-1:0] req_addr,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic              req_wide,
    input  logic              req_tgt_wide,
    input  logic [FULL_W-1:0] req_data,
    input  logic [2*BE_W-1:0] req_be,
    output logic [HALF_W-1:0] bus_ad_lo,
    output logic [HALF_W-1:0] bus_ad_hi,
    output logic [CMD_W-1:0]  bus_cbe_lo,
    output logic [CMD_W-1:0]  bus_cbe_hi,
    output logic              bus_frame,
    output logic              addr_done,
    output logic              data_valid
);
    req_t       rq_in;
    req_t       rq;
    seq_state_t state;
    logic       go;
    logic       dac;
    logic       split;

    // Pack the incoming request and derive control flags.
    always_comb begin
        rq_in.addr_hi  = req_addr[FULL_W-1:HALF_W];
        rq_in.addr_lo  = req_addr[HALF_W-1:0];
        rq_in.cmd      = req_cmd;
        rq_in.wide     = req_wide;
        rq_in.tgt_wide = req_tgt_wide;
        rq_in.data_hi  = req_data[FULL_W-1:HALF_W];
        rq_in.data_lo  = req_data[HALF_W-1:0];
        rq_in.be_hi    = req_be[2*BE_W-1:BE_W];
        rq_in.be_lo    = req_be[BE_W-1:0];
        go    = req_valid && req_ready;
        dac   = |rq.addr_hi;
        split = rq.wide && !rq.tgt_wide;
    end

    aps_req_hold u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (go),
        .d     (rq_in),
        .q     (rq)
    );

    aps_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .dac       (dac),
        .split     (split),
        .state     (state),
        .ready     (req_ready),
        .frame     (bus_frame),
        .last_addr (addr_done),
        .dphase    (data_valid)
    );

    aps_bus_mux #(.DAC_CODE(DAC_CODE)) u_mux (
        .clk    (clk),
        .rst_n  (rst_n),
        .state  (state),
        .rq     (rq),
        .dac    (dac),
        .ad_lo  (bus_ad_lo),
        .ad_hi  (bus_ad_hi),
        .cbe_lo (bus_cbe_lo),
        .cbe_hi (bus_cbe_hi)
    );
endmodule

// File: tb/addr_phase_seq_tb.sv
module addr_phase_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] DAC = 4'b1101;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [63:0] req_addr;
    logic [3:0]  req_cmd;
    logic        req_wide;
    logic        req_tgt_wide;
    logic [63:0] req_data;
    logic [7:0]  req_be;
    logic [31:0] bus_ad_lo, bus_ad_hi;
    logic [3:0]  bus_cbe_lo, bus_cbe_hi;
    logic        bus_frame, addr_done, data_valid;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_phase_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_cmd(req_cmd), .req_wide(req_wide),
        .req_tgt_wide(req_tgt_wide), .req_data(req_data), .req_be(req_be),
        .bus_ad_lo(bus_ad_lo), .bus_ad_hi(bus_ad_hi), .bus_cbe_lo(bus_cbe_lo),
        .bus_cbe_hi(bus_cbe_hi), .bus_frame(bus_frame), .addr_done(addr_done),
        .data_valid(data_valid)
    );

    // Expected beat: {ad_lo, ad_hi, cbe_lo, cbe_hi, frame, done, dval, ready}
    function automatic logic [75:0] beat(input logic [31:0] alo, input logic [31:0] ahi,
                                         input logic [3:0] clo, input logic [3:0] chi,
                                         input logic fr, input logic dn,
                                         input logic dv, input logic rdy);
        return {alo, ahi, clo, chi, fr, dn, dv, rdy};
    endfunction

    task automatic check(input logic [75:0] exp, input string tag);
        logic [75:0] act;
        act = {bus_ad_lo, bus_ad_hi, bus_cbe_lo, bus_cbe_hi,
               bus_frame, addr_done, data_valid, req_ready};
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic garbage();
        req_valid    = 1'b1;
        req_addr     = {$urandom, $urandom};
        req_cmd      = 4'($urandom);
        req_wide     = 1'($urandom);
        req_tgt_wide = 1'($urandom);
        req_data     = {$urandom, $urandom};
        req_be       = 8'($urandom);
    endtask

    // Issue one request and check every cycle until idle again.
    task automatic run_txn(input logic [63:0] a, input logic [3:0] c, input logic w,
                           input logic tw, input logic [63:0] d, input logic [7:0] be);
        bit dac;
        bit split;
        dac   = (a[63:32] != 0);
        split = w && !tw;
        req_valid = 1'b1; req_addr = a; req_cmd = c; req_wide = w;
        req_tgt_wide = tw; req_data = d; req_be = be;
        @(posedge clk); #1;
        garbage();
        @(negedge clk);
        if (dac) begin
            check(beat(a[31:0], a[63:32], DAC, c, 1, 0, 0, 0), "R3 R5 first address cycle");
            @(negedge clk);
            check(beat(a[63:32], a[63:32], c, c, 1, 1, 0, 0), "R4 R5 R6 second address cycle");
        end else begin
            check(beat(a[31:0], 32'h0, c, 4'h0, 1, 1, 0, 0), "R2 R6 single address cycle");
        end
        if (!split) req_valid = 1'b0;
        @(negedge clk);
        if (w && tw)
            check(beat(d[31:0], d[63:32], be[3:0], be[7:4], 0, 0, 1, 0), "R7 wide data phase");
        else if (w)
            check(beat(d[31:0], 32'h0, be[3:0], 4'h0, 0, 0, 1, 0), "R8 split data low");
        else
            check(beat(d[31:0], 32'h0, be[3:0], 4'h0, 0, 0, 1, 0), "R9 narrow data phase");
        if (split) begin
            req_valid = 1'b0;
            @(negedge clk);
            check(beat(d[63:32], 32'h0, be[7:4], 4'h0, 0, 0, 1, 0), "R8 split data high");
        end
        @(negedge clk);
        check(beat(0, 0, 0, 0, 0, 0, 0, 1), "R10 R11 idle gap after transaction");
    endtask

    initial begin
        logic [63:0] a;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_cmd = '0;
        req_wide = 1'b0; req_tgt_wide = 1'b0; req_data = '0; req_be = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(beat(0, 0, 0, 0, 0, 0, 0, 1), "R1 reset state");
        // Directed corner cases
        run_txn(64'h0000_0000_1234_5678, 4'h7, 0, 0, 64'hAAAA_BBBB_CCCC_DDDD, 8'hF3);
        run_txn(64'h0000_0001_0000_0000, 4'h6, 1, 1, 64'h1111_2222_3333_4444, 8'h5A);
        run_txn(64'hFFFF_FFFF_FFFF_FFFC, 4'hF, 1, 0, 64'h8765_4321_0FED_CBA9, 8'hC3);
        run_txn(64'h0000_0000_FFFF_FFFF, 4'h2, 1, 0, 64'hDEAD_BEEF_CAFE_F00D, 8'h0F);
        run_txn(64'h8000_0000_0000_0000, 4'hC, 0, 1, 64'h0123_4567_89AB_CDEF, 8'hFF);
        // Random requests
        for (int i = 0; i < 300; i++) begin
            a = {($urandom_range(0, 1) == 0) ? 32'h0 : 32'($urandom), 32'($urandom)};
            run_txn(a, 4'($urandom), 1'($urandom), 1'($urandom),
                    {$urandom, $urandom}, 8'($urandom));
        end
        // R10: hold valid low through several idle cycles; nothing starts
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(beat(0, 0, 0, 0, 0, 0, 0, 1), "R10 R11 idle with no request");
        end
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule